// File: doc/BRIEF.md
# Round-to-Nearest-Even Product Rounder

This combinational stage sits behind a single-precision multiplier's normaliser. Its inputs are the result sign, a 48-bit significand product with the leading one at bit 47, a 12-bit two's-complement unbiased exponent, and the 8-bit biased exponent field the caller has already worked out. The low 24 bits of the product are the discarded fraction. The stage rounds the product to 24 significant bits using round-to-nearest, ties-to-even, and emits a packed 32-bit IEEE 754 single-precision word.

Three cases need special handling:
- Rounding can carry out of the 48-bit significand. The stage then renormalises and bumps both exponents.
- A subnormal input can round up into the hidden-bit position. The stage then promotes it to the smallest normal exponent field.
- The exponent can be too large for the format. The stage then saturates to signed infinity.

For subnormal results, the caller passes an exponent field of zero and a product already shifted right with sticky bits merged.

Top module: `rne_rounder`

## Requirements
- R1: Output bit 31 equals `sign_i` for every input.
- R2: When `prod_i[23:0]` is below 0x800000 and no overflow applies, the mantissa field (output bits 22:0) equals `prod_i[46:24]`.
- R3: When `prod_i[23:0]` is above 0x800000, the kept 24 bits `prod_i[47:24]` are incremented by one.
- R4: When `prod_i[23:0]` equals 0x800000 and `prod_i[24]` is 0, the product is not rounded up.
- R5: When `prod_i[23:0]` equals 0x800000 and `prod_i[24]` is 1, the kept bits are incremented by one.
- R6: When the increment carries out of bit 47, the mantissa field becomes 0. The exponent field output (bits 30:23) becomes `exp_fld_i + 1`. The unbiased exponent used for the overflow test becomes `exp_i + 1`.
- R7: Bit 47 of the rounded product is the implicit one and does not appear in the output. The mantissa field is rounded bits 46:24.
- R8: When `exp_fld_i` is 0 and the rounded product has bit 47 set, the exponent field output is 0x01.
- R9: When `exp_fld_i` is 0 and the rounded product has bit 47 clear, the exponent field output stays 0x00.
- R10: When the unbiased exponent, after any carry adjustment, is at least +128, the output is infinity: exponent field 0xFF, mantissa 0, sign preserved.
- R11: The exponent comparison is signed. An exponent of +127, or any negative exponent such as 0x800 (-2048), gives a finite result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Sign of the result |
| prod_i | input | 48 | Normalised significand product, leading one at bit 47 |
| exp_i | input | 12 | Two's-complement unbiased exponent |
| exp_fld_i | input | 8 | Tentative biased exponent field (0 for subnormal path) |
| result_o | output | 32 | Packed single-precision result |

## Verification
The stage holds no state, so a wrong internal decision shows up in `result_o` in the same cycle the inputs change. The only question is which bit pattern exposes it:
- A mis-taken tie decision changes the mantissa LSB by one.
- A lost carry leaves an all-ones mantissa where zero is expected, and the exponent field one too low.
- A broken signed compare turns large negative exponents into infinity, or lets +128 through as a finite value.

The bench compares every vector against a behavioural model on the clock after it is applied. It drives ties with even and odd kept LSBs, the all-ones carry, the subnormal promotion edge, the +127/+128 boundary and random patterns.

// File: rtl/rne_pkg.sv
package rne_pkg;
  localparam int SIG_W  = 24;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EXP_W  = 12;
  localparam int FLD_W  = 8;
  localparam int MANT_W = SIG_W - 1;
  localparam int RES_W  = 1 + FLD_W + MANT_W;
endpackage

// File: rtl/rne_decide.sv
module rne_decide #(
  parameter int SIG_W = rne_pkg::SIG_W
) (
  input  logic [SIG_W:0] tail_i,   // kept LSB plus discarded fraction
  output logic           round_up_o
);
  localparam logic [SIG_W-1:0] HALF = {1'b1, {(SIG_W-1){1'b0}}};

  logic [SIG_W-1:0] frac;
  logic             kept_lsb;
  logic             tie;

  always_comb begin
    frac     = tail_i[SIG_W-1:0];
    kept_lsb = tail_i[SIG_W];
    tie      = (frac == HALF);
    round_up_o = tie ? kept_lsb : (frac > HALF);
  end
endmodule

// File: rtl/rne_adjust.sv
module rne_adjust #(
  parameter int SIG_W  = rne_pkg::SIG_W,
  parameter int PROD_W = rne_pkg::PROD_W,
  parameter int EXP_W  = rne_pkg::EXP_W,
  parameter int FLD_W  = rne_pkg::FLD_W
) (
  input  logic [PROD_W-1:0] prod_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FLD_W-1:0]  fld_i,
  input  logic              round_up_i,
  output logic [PROD_W-1:0] prod_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FLD_W-1:0]  fld_o,
  output logic              carry_o
);
  localparam logic [PROD_W:0] INC =
    {{(PROD_W+1-SIG_W){1'b0}}, 1'b1, {(SIG_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] TOP_BIT = {1'b1, {(PROD_W-1){1'b0}}};

  logic [PROD_W:0] sum;

  always_comb begin
    sum     = {1'b0, prod_i} + INC;
    carry_o = round_up_i & sum[PROD_W];
    prod_o  = prod_i;
    exp_o   = exp_i;
    fld_o   = fld_i;
    if (carry_o) begin
      prod_o = (sum[PROD_W-1:0] >> 1) | TOP_BIT;
      exp_o  = exp_i + EXP_W'(1);
      fld_o  = fld_i + FLD_W'(1);
    end else if (round_up_i) begin
      prod_o = sum[PROD_W-1:0];
    end
  end
endmodule

// File: rtl/rne_pack.sv
module rne_pack #(
  parameter int SIG_W = rne_pkg::SIG_W,
  parameter int EXP_W = rne_pkg::EXP_W,
  parameter int FLD_W = rne_pkg::FLD_W,
  parameter int RES_W = 1 + FLD_W + SIG_W - 1
) (
  input  logic             sign_i,
  input  logic [SIG_W-1:0] sig_i,   // rounded top bits, msb is hidden one
  input  logic [EXP_W-1:0] exp_i,
  input  logic [FLD_W-1:0] fld_i,
  output logic [RES_W-1:0] result_o
);
  localparam int MANT_W = SIG_W - 1;
  localparam logic [EXP_W-1:0] E_MAX   = EXP_W'(1) << (FLD_W - 1);
  localparam logic [EXP_W-1:0] SGN_FLP = {1'b1, {(EXP_W-1){1'b0}}};

  logic             in_range;
  logic [FLD_W-1:0] fld_out;

  always_comb begin
    // signed compare as unsigned after flipping the sign bit
    in_range = ((exp_i ^ SGN_FLP) < (E_MAX ^ SGN_FLP));
    fld_out  = fld_i;
    if (fld_i == '0 && sig_i[SIG_W-1]) fld_out = FLD_W'(1);
    if (in_range)
      result_o = {sign_i, fld_out, sig_i[MANT_W-1:0]};
    else
      result_o = {sign_i, {FLD_W{1'b1}}, {MANT_W{1'b0}}};
  end
endmodule

// File: rtl/rne_rounder.sv
module rne_rounder
  import rne_pkg::*;
#(
  parameter int P_SIG_W = SIG_W,
  parameter int P_EXP_W = EXP_W,
  parameter int P_FLD_W = FLD_W
) (
  input  logic                       sign_i,
  input  logic [2*P_SIG_W-1:0]       prod_i,
  input  logic [P_EXP_W-1:0]         exp_i,
  input  logic [P_FLD_W-1:0]         exp_fld_i,
  output logic [P_FLD_W+P_SIG_W-1:0] result_o
);
  localparam int L_PROD_W = 2 * P_SIG_W;
  localparam int L_MANT_W = P_SIG_W - 1;
  localparam int L_RES_W  = P_FLD_W + P_SIG_W;
  localparam int E_MAX    = 1 << (P_FLD_W - 1);

  logic                  round_up;
  logic                  carry;
  logic [L_PROD_W-1:0]   prod_adj;
  logic [P_EXP_W-1:0]    exp_adj;
  logic [P_FLD_W-1:0]    fld_adj;

  rne_decide #(.SIG_W(P_SIG_W)) u_decide (
    .tail_i     (prod_i[P_SIG_W:0]),
    .round_up_o (round_up)
  );

  rne_adjust #(
    .SIG_W(P_SIG_W), .PROD_W(L_PROD_W), .EXP_W(P_EXP_W), .FLD_W(P_FLD_W)
  ) u_adjust (
    .prod_i     (prod_i),
    .exp_i      (exp_i),
    .fld_i      (exp_fld_i),
    .round_up_i (round_up),
    .prod_o     (prod_adj),
    .exp_o      (exp_adj),
    .fld_o      (fld_adj),
    .carry_o    (carry)
  );

  rne_pack #(
    .SIG_W(P_SIG_W), .EXP_W(P_EXP_W), .FLD_W(P_FLD_W), .RES_W(L_RES_W)
  ) u_pack (
    .sign_i   (sign_i),
    .sig_i    (prod_adj[L_PROD_W-1 -: P_SIG_W]),
    .exp_i    (exp_adj),
    .fld_i    (fld_adj),
    .result_o (result_o)
  );

  logic adj_ovf;
  logic in_ovf;
  always_comb begin
    adj_ovf = ($signed(exp_adj) >= E_MAX);
    in_ovf  = ($signed(exp_i) >= E_MAX);

    assert_sign_pass_R1: assert (result_o[L_RES_W-1] == sign_i)
      else $error("sign not passed through");
    assert_trunc_R2: assert (round_up || adj_ovf ||
                             result_o[L_MANT_W-1:0] == prod_i[L_PROD_W-2 -: L_MANT_W])
      else $error("unrounded mantissa altered");
    assert_carry_R6: assert (!carry || result_o[L_MANT_W-1:0] == '0)
      else $error("carry-out mantissa not zero");
    assert_infinity_R10: assert (!in_ovf ||
      result_o[L_RES_W-2:0] == {{P_FLD_W{1'b1}}, {L_MANT_W{1'b0}}})
      else $error("overflow exponent not saturated");
    assert_promote_R8: assert (!(exp_fld_i == '0 && prod_adj[L_PROD_W-1] && !adj_ovf) ||
      result_o[L_RES_W-2 -: P_FLD_W] == P_FLD_W'(1))
      else $error("subnormal not promoted");
  end
endmodule

// File: tb/rne_rounder_tb.sv
module rne_rounder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        sign;
  logic [47:0] prod;
  logic [11:0] expo;
  logic [7:0]  fld;
  logic [31:0] res;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rne_rounder u_dut (
    .sign_i    (sign),
    .prod_i    (prod),
    .exp_i     (expo),
    .exp_fld_i (fld),
    .result_o  (res)
  );

  function automatic logic [31:0] model(logic s, logic [47:0] p, logic [11:0] e,
                                        logic [7:0] f);
    longint kept = longint'(p >> 24);
    longint rem  = longint'(p & 48'hFFFFFF);
    logic [11:0] ee = e;
    logic [7:0]  ff = f;
    if (rem > 64'h800000 || (rem == 64'h800000 && kept[0])) kept = kept + 1;
    if (kept == 64'h1000000) begin
      kept = 64'h800000;
      ee = ee + 12'd1;
      ff = ff + 8'd1;
    end
    if ($signed(ee) >= 128) return {s, 8'hFF, 23'd0};
    if (ff == 8'd0 && kept >= 64'h800000) ff = 8'd1;
    return {s, ff, kept[22:0]};
  endfunction

  task automatic run(string tag, logic s, logic [47:0] p, logic [11:0] e,
                     logic [7:0] f, logic [31:0] want);
    @(negedge clk);
    sign = s; prod = p; expo = e; fld = f;
    @(posedge clk);
    #1;
    n_tests++;
    if (res !== want) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h (p=%012h e=%03h f=%02h)",
               tag, res, want, p, e, f);
    end
  endtask

  initial begin
    int cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    sign = 1'b0; prod = '0; expo = '0; fld = '0;
    // idle inputs give +0
    run("R1 idle", 0, 48'h0, 12'h000, 8'h00, 32'h0000_0000);
    run("R1", 1, 48'h800000_000000, 12'h000, 8'd127, 32'hBF80_0000);
    run("R2", 0, 48'hC00001_7FFFFF, 12'h000, 8'd127, 32'h3FC0_0001);
    run("R3", 0, 48'hC00001_800001, 12'h000, 8'd127, 32'h3FC0_0002);
    run("R4", 0, 48'hC00002_800000, 12'h000, 8'd127, 32'h3FC0_0002);
    run("R5", 0, 48'hC00001_800000, 12'h000, 8'd127, 32'h3FC0_0002);
    run("R6", 0, 48'hFFFFFF_800000, 12'h000, 8'd127, 32'h4000_0000);
    run("R6 R7", 1, 48'hFFFFFF_FFFFFF, 12'h010, 8'd143, 32'hC800_0000);
    run("R8", 0, 48'h7FFFFF_800000, 12'hF82, 8'h00, 32'h0080_0000);
    run("R9", 0, 48'h7FFFFF_7FFFFF, 12'hF82, 8'h00, 32'h007F_FFFF);
    run("R10", 1, 48'h800000_000000, 12'h080, 8'hFF, 32'hFF80_0000);
    run("R10 carry", 0, 48'hFFFFFF_FFFFFF, 12'h07F, 8'hFE, 32'h7F80_0000);
    run("R11", 0, 48'hFFFFFF_000000, 12'h07F, 8'hFE, 32'h7F7F_FFFF);
    run("R11 neg", 0, 48'h800000_000000, 12'h800, 8'h01, 32'h0080_0000);
    for (int i = 0; i < 400; i++) begin
      logic        s = 1'($urandom);
      logic [47:0] p = {1'b1, 15'($urandom), 32'($urandom)};
      logic [11:0] e = 12'($urandom_range(0, 300)) - 12'd150;
      logic [7:0]  f = 8'($urandom);
      if (i % 4 == 0) p[23:0] = 24'h800000;
      if (i % 8 == 1) begin p[47] = 1'b0; f = 8'h00; end
      run("R7 random", s, p, e, f, model(s, p, e, f));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule